// File: doc/BRIEF.md
# Block Transpose FIR Filter

This block is a synchronous finite impulse response filter that accepts a block of `BLK` new unsigned samples in every valid cycle and returns a block of `BLK` filtered results. Its `TAPS` coefficients are cut into `TAPS/BLK` groups of `BLK` coefficients each. One window of recent samples is formed per block and multiplied by every coefficient group in the same cycle. The group results then travel through a chain of block-wide delay registers, so each output block sums the contributions of the current and earlier blocks.

The multipliers are built from 2-bit by 2-bit cells whose crosswise partial products are shifted and summed. An optional register after the products shortens the critical path at the cost of one cycle of latency. Idle cycles, where `in_valid_i` is low, do not advance the filter. The sample stream is therefore the concatenation of valid blocks only. Coefficients are static inputs that the user changes only alongside a valid block.

Top module: `blk_fir`

## Requirements
- R1: Sample l of a block is `in_data_i[l*DW +: DW]`, and later lanes are later in time. Coefficient h(i) is `coef_i[i*CW +: CW]`, and result lane l is `out_data_o[l*AW +: AW]`. Number the samples of valid blocks 0, 1, 2, ... from reset. The result for sample n is then the sum over i of h(i)·x(n−i), where samples before the first one count as zero.
- R2: `out_valid_o` is high exactly 2 cycles after a rising edge at which `in_valid_i` was high (1 cycle with `PIPE_PROD` = 0), and low otherwise.
- R3: Each result lane is AW = 11 bits wide and never wraps. With all samples and coefficients at 15, the steady result is 1350 in every lane.
- R4: A cycle with `in_valid_i` low leaves `out_data_o` unchanged, and the samples presented in that cycle do not enter the filter.
- R5: While `rst_ni` is low, `out_valid_o` and `out_data_o` are 0. The stored sample history and all block delay registers are cleared to zero.
- R6: A single sample of value 1 in lane 0, followed by zero blocks, produces h(0) to h(TAPS−1) in lane order over successive output blocks.
- R7: Every product of a 4-bit sample and a 4-bit coefficient is exact for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input block qualifier |
| in_data_i | input | BLK*DW | Input block, lane 0 oldest |
| coef_i | input | TAPS*CW | Coefficients, h(0) in the low bits |
| out_valid_o | output | 1 | Output block qualifier |
| out_data_o | output | BLK*AW | Output block, lane 0 oldest |

## Verification
Two events can fall in the same cycle: the delay chain advancing with the last pending product block, and an idle input cycle. In that cycle the output must take the new sum while nothing new enters the filter. The next cycle must then hold that sum. Random stimulus leaves about three cycles in ten idle, so gaps land right behind valid blocks. Every cycle's output valid and data are compared with a direct convolution over the gap-free sample stream, and the expected value is held through gaps.

// File: rtl/blk_fir_pkg.sv
package blk_fir_pkg;
  // result width that holds the sum of TAPS full-scale products
  function automatic int sum_width(int dw, int cw, int taps);
    return dw + cw + $clog2(taps);
  endfunction
  function automatic int max_sum(int dw, int cw, int taps);
    return taps * ((2 ** dw) - 1) * ((2 ** cw) - 1);
  endfunction
endpackage

// File: rtl/crs_dig2.sv
module crs_dig2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic cross_s, cross_c, hi;

  assign cross_s = (a_i[1] & b_i[0]) ^ (a_i[0] & b_i[1]);
  assign cross_c = (a_i[1] & b_i[0]) & (a_i[0] & b_i[1]);
  assign hi      = a_i[1] & b_i[1];

  assign p_o[0] = a_i[0] & b_i[0];
  assign p_o[1] = cross_s;
  assign p_o[2] = hi ^ cross_c;
  assign p_o[3] = hi & cross_c;
endmodule

// File: rtl/crs_mul.sv
// Multiplier from 2x2 digit cells; AW and BW must be even.
module crs_mul #(
  parameter int AW = 4,
  parameter int BW = 4
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int NA = AW / 2;
  localparam int NB = BW / 2;
  localparam int PW = AW + BW;

  logic [3:0] dig [NA][NB];

  for (genvar ga = 0; ga < NA; ga++) begin : g_a
    for (genvar gb = 0; gb < NB; gb++) begin : g_b
      crs_dig2 u_dig (
        .a_i(a_i[2*ga +: 2]),
        .b_i(b_i[2*gb +: 2]),
        .p_o(dig[ga][gb])
      );
    end
  end

  // sum each crosswise diagonal at its weight
  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int d = 0; d < NA + NB - 1; d++) begin
      for (int i = 0; i < NA; i++) begin
        if (d - i >= 0 && d - i < NB) begin
          acc = acc + (PW'(dig[i][d-i]) << (2 * d));
        end
      end
    end
    p_o = acc;
  end
endmodule

// File: rtl/blk_subprod.sv
// One coefficient group times the sample window, BLK lanes.
module blk_subprod #(
  parameter int DW  = 4,
  parameter int CW  = 4,
  parameter int BLK = 2,
  parameter int AW  = 11
) (
  input  logic [(2*BLK-1)*DW-1:0] win_i,
  input  logic [BLK*CW-1:0]       coef_i,
  output logic [BLK*AW-1:0]       sum_o
);
  localparam int PW = DW + CW;

  logic [PW-1:0] prod [BLK][BLK];

  // lane l, coef j uses sample at window slot BLK-1+l-j
  for (genvar gl = 0; gl < BLK; gl++) begin : g_lane
    for (genvar gj = 0; gj < BLK; gj++) begin : g_coef
      crs_mul #(.AW(DW), .BW(CW)) u_mul (
        .a_i(win_i[(BLK-1+gl-gj)*DW +: DW]),
        .b_i(coef_i[gj*CW +: CW]),
        .p_o(prod[gl][gj])
      );
    end
  end

  always_comb begin
    for (int l = 0; l < BLK; l++) begin
      logic [AW-1:0] s;
      s = '0;
      for (int j = 0; j < BLK; j++) s = s + AW'(prod[l][j]);
      sum_o[l*AW +: AW] = s;
    end
  end
endmodule

// File: rtl/blk_fir.sv
module blk_fir
  import blk_fir_pkg::*;
#(
  parameter int DW        = 4,
  parameter int CW        = 4,
  parameter int TAPS      = 6,
  parameter int BLK       = 2,
  parameter bit PIPE_PROD = 1'b1,
  parameter int AW        = sum_width(DW, CW, TAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [BLK*DW-1:0]    in_data_i,
  input  logic [TAPS*CW-1:0]   coef_i,
  output logic                 out_valid_o,
  output logic [BLK*AW-1:0]    out_data_o
);
  localparam int NGRP = TAPS / BLK;
  localparam int WW   = (2 * BLK - 1) * DW;
  localparam int MAXY = max_sum(DW, CW, TAPS);

  logic [WW-1:0]       win;
  logic [BLK*AW-1:0]   grp_sum [NGRP];
  logic [BLK*AW-1:0]   grp_q   [NGRP];
  logic [BLK*AW-1:0]   chain_nxt [NGRP];
  logic                p_vld;

  // sample window: previous BLK-1 samples below the current block
  if (BLK > 1) begin : g_hist
    logic [(BLK-1)*DW-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         hist_q <= '0;
      else if (in_valid_i) hist_q <= in_data_i[BLK*DW-1 -: (BLK-1)*DW];
    end
    assign win = {in_data_i, hist_q};

    assert_hist_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> hist_q == $past(in_data_i[BLK*DW-1 -: (BLK-1)*DW]));
  end else begin : g_nohist
    assign win = in_data_i;
  end

  for (genvar gm = 0; gm < NGRP; gm++) begin : g_grp
    blk_subprod #(.DW(DW), .CW(CW), .BLK(BLK), .AW(AW)) u_sub (
      .win_i (win),
      .coef_i(coef_i[gm*BLK*CW +: BLK*CW]),
      .sum_o (grp_sum[gm])
    );
  end

  if (PIPE_PROD) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_vld <= 1'b0;
        for (int m = 0; m < NGRP; m++) grp_q[m] <= '0;
      end else begin
        p_vld <= in_valid_i;
        if (in_valid_i) begin
          for (int m = 0; m < NGRP; m++) grp_q[m] <= grp_sum[m];
        end
      end
    end

    assert_pipe_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> p_vld);
  end else begin : g_nopipe
    assign p_vld = in_valid_i;
    always_comb begin
      for (int m = 0; m < NGRP; m++) grp_q[m] = grp_sum[m];
    end
  end

  // transpose chain: highest group enters first, group 0 added undelayed
  if (NGRP > 1) begin : g_chain
    logic [BLK*AW-1:0] dly_q [NGRP-1];

    always_comb begin
      chain_nxt[NGRP-1] = grp_q[NGRP-1];
      for (int m = 0; m < NGRP - 1; m++) begin
        for (int l = 0; l < BLK; l++) begin
          chain_nxt[m][l*AW +: AW] = grp_q[m][l*AW +: AW] + dly_q[m][l*AW +: AW];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int m = 0; m < NGRP - 1; m++) dly_q[m] <= '0;
      end else if (p_vld) begin
        for (int m = 0; m < NGRP - 1; m++) dly_q[m] <= chain_nxt[m+1];
      end
    end

    assert_chain_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !p_vld |=> $stable(dly_q[0]));
  end else begin : g_single
    assign chain_nxt[0] = grp_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= p_vld;
      if (p_vld) out_data_o <= chain_nxt[0];
    end
  end

  assert_out_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_vld |=> out_valid_o);
  assert_out_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_vld |=> !out_valid_o);
  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_vld |=> $stable(out_data_o));
  assert_rst_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o && out_data_o == '0);

  for (genvar gl = 0; gl < BLK; gl++) begin : g_ovf
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> out_data_o[gl*AW +: AW] <= AW'(MAXY));
  end
endmodule

// File: tb/test_blk_fir.sv
`timescale 1ns/1ps
module test_blk_fir;
  localparam int DW   = 4;
  localparam int CW   = 4;
  localparam int TAPS = 6;
  localparam int BLK  = 2;
  localparam int AW   = 11;
  localparam int LAT  = 2;
  localparam int MAXS = 4096;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 in_valid_i = 1'b0;
  logic [BLK*DW-1:0]    in_data_i = '0;
  logic [TAPS*CW-1:0]   coef_i = '0;
  logic                 out_valid_o;
  logic [BLK*AW-1:0]    out_data_o;

  blk_fir #(.DW(DW), .CW(CW), .TAPS(TAPS), .BLK(BLK), .PIPE_PROD(1'b1)) i_blk_fir (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .coef_i, .out_valid_o, .out_data_o
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int xs [MAXS];
  int ns = 0;
  int h [TAPS];
  logic              qv [LAT+1];
  logic [BLK*AW-1:0] qd [LAT+1];
  logic [BLK*AW-1:0] hold_d;

  function automatic int conv(int n);
    int s = 0;
    for (int i = 0; i < TAPS; i++) if (n - i >= 0) s += h[i] * xs[n-i];
    return s;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_coef();
    for (int i = 0; i < TAPS; i++) coef_i[i*CW +: CW] = CW'(h[i]);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    in_data_i = '0;
    ns = 0;
    hold_d = '0;
    for (int s = 0; s <= LAT; s++) begin qv[s] = 1'b0; qd[s] = '0; end
    repeat (3) @(posedge clk_i);
    #1;
    chk("R5", "reset valid", 64'(out_valid_o), 64'd0);
    chk("R5", "reset data", 64'(out_data_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // present one cycle of input, then check the outputs after the next edge
  task automatic cycle(bit v, logic [BLK*DW-1:0] d, string req);
    logic [BLK*AW-1:0] e = '0;
    in_valid_i = v;
    in_data_i  = d;
    apply_coef();
    if (v) begin
      for (int l = 0; l < BLK; l++) begin xs[ns] = int'(d[l*DW +: DW]); ns++; end
      for (int l = 0; l < BLK; l++) e[l*AW +: AW] = AW'(conv(ns - BLK + l));
    end
    @(posedge clk_i);
    #1;
    for (int s = LAT; s >= 2; s--) begin qv[s] = qv[s-1]; qd[s] = qd[s-1]; end
    qv[1] = v;
    qd[1] = e;
    if (qv[LAT]) hold_d = qd[LAT];
    chk("R2", "out_valid", 64'(out_valid_o), 64'(qv[LAT]));
    chk(req, qv[LAT] ? "out_data" : "held out_data", 64'(out_data_o), 64'(hold_d));
    in_valid_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < TAPS; i++) h[i] = 0;
    do_reset();

    // R6: impulse in lane 0, then in lane 1
    for (int i = 0; i < TAPS; i++) h[i] = i + 3;
    cycle(1'b1, {4'd0, 4'd1}, "R6");
    for (int k = 0; k < 5; k++) cycle(1'b1, '0, "R6");
    cycle(1'b1, {4'd1, 4'd0}, "R6");
    for (int k = 0; k < 5; k++) cycle(1'b1, '0, "R6");

    // R7: all operand pairs through h(0)
    do_reset();
    for (int b = 0; b < 16; b++) begin
      for (int a = 0; a < 16; a++) begin
        for (int i = 0; i < TAPS; i++) h[i] = 0;
        h[0] = b;
        cycle(1'b1, {4'(15 - a), 4'(a)}, "R7");
      end
    end

    // R3: full scale everywhere
    do_reset();
    for (int i = 0; i < TAPS; i++) h[i] = 15;
    for (int k = 0; k < 6; k++) cycle(1'b1, {4'd15, 4'd15}, "R3");
    cycle(1'b0, '0, "R3");
    chk("R3", "full scale lane1", 64'(out_data_o[AW +: AW]), 64'd1350);

    // R1/R4: random coefficients, random data with idle gaps
    do_reset();
    for (int i = 0; i < TAPS; i++) h[i] = int'($urandom % 16);
    for (int k = 0; k < 900; k++) begin
      bit v = ($urandom % 10) < 7;
      cycle(v, BLK*DW'($urandom), v ? "R1" : "R4");
    end
    for (int k = 0; k < LAT + 2; k++) cycle(1'b0, 8'hA5, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule